// File: doc/BRIEF.md
# Serial Register Link Master

This block is the host end of a five-wire link to an attached register device. A request port asks for one access at a time. Each access carries a write flag, a 7-bit register address and a 16-bit data word. The master turns the request into a framed serial exchange:

- A low pulse on the clear line opens the frame.
- A train of strobe pulses follows, with frame bits presented on the serial input line.
- For reads, the reply bits are collected from the serial output line.
- A final acknowledge strobe closes the frame, and a one-clock done pulse reports completion.

A separate initialise request produces a single low pulse on the device reset line.

Strobe timing comes from two parameters that set the low and high half-periods in system clocks. Values below two are raised to two. Between accesses the link rests with clear and reset high, and with strobe and serial input low. The busy output tells the requester when a new request will be taken.

Top module: `serreg_master`

## Requirements
- R1: After reset and between accesses, busy is low, link_clr_n and link_rst_n are high, and link_strb and link_din are low.
- R2: An access starts with exactly one low pulse on link_clr_n lasting HALF_LO clocks while link_strb is low. It is followed by HALF_LO clocks of quiet link and then the low phase of the first strobe.
- R3: The 24-bit frame is sent in order, frame bit k during strobe pulse k (k = 0..23, counting from 0). Bit 0 is the write flag (1 = write, 0 = read). Bits 1..7 carry the address, least significant bit first. Bits 8..23 carry the data, least significant bit first.
- R4: For a write, all 24 frame bits are driven on link_din. Each bit is set up in the low phase before its strobe rises and is held unchanged while the strobe is high.
- R5: For a read, only frame bits 0..7 are driven and link_din stays low for the later pulses. Reply bit j (j = 0..15) of rdata is the value of link_dout at the falling edge that ends strobe pulse 8+j.
- R6: Every access issues exactly 25 strobe pulses; the 25th is the acknowledge.
- R7: Each strobe high phase lasts HALF_HI clocks and each low phase between pulses lasts HALF_LO clocks.
- R8: busy is high from the clock after a request is taken until done pulses. Requests and initialise requests that arrive while busy is high are ignored.
- R9: done is high for exactly one clock, in the clock in which the last strobe has fallen. After a read, rdata holds the reply at that point.
- R10: An initialise request taken while idle drives link_rst_n low for HALF_LO clocks and then high. No clear or strobe activity occurs, and done pulses at the end. If init_req and req arrive in the same idle clock, the initialise request wins and the access request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write data |
| init_req | input | 1 | Request a device reset pulse |
| busy | output | 1 | An access or reset pulse is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read reply, valid at done after a read |
| link_clr_n | output | 1 | Frame clear line, active low |
| link_strb | output | 1 | Bit strobe |
| link_din | output | 1 | Serial bit toward the device |
| link_dout | input | 1 | Serial bit from the device |
| link_rst_n | output | 1 | Device reset line, active low |

## Verification
The bench builds the master with HALF_LO = 3 and HALF_HI = 2. Because the two half-periods differ, a swapped or miscounted phase shows up in the measured widths of the clear pulse, the strobe high and low phases and the reset pulse. The first strobe's low phase must span exactly the quiet gap plus one low half-period, which exposes a missing or doubled gap. A device model on the bench records link_din at each strobe rise and returns reply bits on link_dout. Word patterns with a single edge bit set, all ones and all zeros, together with the extreme addresses, expose bit-order and field-position faults.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int ADDR_BITS  = 7;
  localparam int DATA_BITS  = 16;
  localparam int HDR_BITS   = 1 + ADDR_BITS;
  localparam int FRAME_BITS = HDR_BITS + DATA_BITS;
  localparam int PULSES     = FRAME_BITS + 1;
  localparam int IDX_W      = $clog2(PULSES);
  localparam int RIDX_W     = $clog2(DATA_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLO,
    ST_CLRLO,
    ST_GAP,
    ST_SLO,
    ST_SHI
  } seq_state_e;

  function automatic logic [FRAME_BITS-1:0] pack_frame(
    input logic                 wr,
    input logic [ADDR_BITS-1:0] addr,
    input logic [DATA_BITS-1:0] data
  );
    return {data, addr, wr};
  endfunction
endpackage

// File: rtl/serreg_timer.sv
module serreg_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != '0);
    cnt_d  = restart ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
  import serreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 ld_write,
  input  logic [ADDR_BITS-1:0] ld_addr,
  input  logic [DATA_BITS-1:0] ld_wdata,
  input  logic [IDX_W-1:0]     bit_idx,
  input  logic                 drive_en,
  input  logic                 capture,
  input  logic                 dout,
  output logic                 din,
  output logic [DATA_BITS-1:0] rdata
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [FRAME_BITS-1:0] frame_d;
  logic [DATA_BITS-1:0]  rdata_q;
  logic [DATA_BITS-1:0]  rdata_d;
  logic                  in_frame;
  logic                  in_reply;
  logic                  cur_bit;
  logic                  cap_en;
  logic [RIDX_W-1:0]     ridx;

  always_comb begin
    in_frame = bit_idx < IDX_W'(FRAME_BITS);
    in_reply = in_frame && (bit_idx >= IDX_W'(HDR_BITS));
    ridx     = RIDX_W'(bit_idx - IDX_W'(HDR_BITS));
    cur_bit  = in_frame ? frame_q[bit_idx] : 1'b0;
    // reads leave the data field undriven (low)
    din      = drive_en && cur_bit && (frame_q[0] || !in_reply);
    frame_d  = pack_frame(ld_write, ld_addr, ld_wdata);
    cap_en   = capture && !frame_q[0] && in_reply;
    rdata_d  = rdata_q;
    rdata_d[ridx] = dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (load) begin
      frame_q <= frame_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/serreg_master.sv
module serreg_master
  import serreg_pkg::*;
#(
  parameter int HALF_LO = 4,
  parameter int HALF_HI = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 req_write,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic                 init_req,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 link_clr_n,
  output logic                 link_strb,
  output logic                 link_din,
  input  logic                 link_dout,
  output logic                 link_rst_n
);
  localparam int LO_EFF = (HALF_LO < 2) ? 2 : HALF_LO;
  localparam int HI_EFF = (HALF_HI < 2) ? 2 : HALF_HI;
  localparam int MAX_H  = (LO_EFF > HI_EFF) ? LO_EFF : HI_EFF;
  localparam int CNT_W  = $clog2(MAX_H);
  localparam logic [CNT_W-1:0] LO_RELOAD = CNT_W'(LO_EFF - 1);
  localparam logic [CNT_W-1:0] HI_RELOAD = CNT_W'(HI_EFF - 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PULSES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             restart;
  logic [CNT_W-1:0] reload;
  logic             tc;
  logic             load_frame;
  logic             capture;
  logic             drive_en;

  serreg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .reload  (reload),
    .expired (tc)
  );

  serreg_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_frame),
    .ld_write (req_write),
    .ld_addr  (req_addr),
    .ld_wdata (req_wdata),
    .bit_idx  (idx_q),
    .drive_en (drive_en),
    .capture  (capture),
    .dout     (link_dout),
    .din      (link_din),
    .rdata    (rdata)
  );

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    done_d     = 1'b0;
    restart    = 1'b0;
    reload     = LO_RELOAD;
    load_frame = 1'b0;
    capture    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (init_req) begin
          state_d = ST_RSTLO;
          restart = 1'b1;
        end else if (req) begin
          state_d    = ST_CLRLO;
          restart    = 1'b1;
          load_frame = 1'b1;
        end
      end
      ST_RSTLO: begin
        if (tc) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_CLRLO: begin
        if (tc) begin
          state_d = ST_GAP;
          restart = 1'b1;
        end
      end
      ST_GAP: begin
        if (tc) begin
          state_d = ST_SLO;
          idx_d   = '0;
          restart = 1'b1;
        end
      end
      ST_SLO: begin
        if (tc) begin
          state_d = ST_SHI;
          restart = 1'b1;
          reload  = HI_RELOAD;
        end
      end
      ST_SHI: begin
        if (tc) begin
          capture = 1'b1;
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_SLO;
            idx_d   = idx_q + 1'b1;
            restart = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign drive_en   = (state_q == ST_SLO) || (state_q == ST_SHI);
  assign link_strb  = (state_q == ST_SHI);
  assign link_clr_n = (state_q != ST_CLRLO);
  assign link_rst_n = (state_q != ST_RSTLO);
endmodule

// File: rtl/serreg_master_chk.sv
module serreg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic link_clr_n,
  input logic link_strb,
  input logic link_din,
  input logic link_rst_n
);
  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (link_clr_n && link_rst_n && !link_strb && !link_din));

  // R2
  clr_quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_clr_n |-> !link_strb);

  // R4
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_strb && $past(link_strb)) |-> $stable(link_din));

  // R8
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  rst_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rst_n |-> (link_clr_n && !link_strb));
endmodule

bind serreg_master serreg_master_chk u_chk (.*);

// File: tb/serreg_master_bench.sv
module serreg_master_bench;
  import serreg_pkg::*;

  localparam int LO = 3;
  localparam int HI = 2;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        req_write;
  logic [6:0]  req_addr;
  logic [15:0] req_wdata;
  logic        init_req;
  logic        busy;
  logic        done;
  logic [15:0] rdata;
  logic        link_clr_n;
  logic        link_strb;
  logic        link_din;
  logic        link_dout;
  logic        link_rst_n;

  serreg_master #(.HALF_LO(LO), .HALF_HI(HI)) u_serreg_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .init_req(init_req),
    .busy(busy), .done(done), .rdata(rdata), .link_clr_n(link_clr_n),
    .link_strb(link_strb), .link_din(link_din), .link_dout(link_dout),
    .link_rst_n(link_rst_n)
  );

  typedef struct {
    logic [23:0] frame;
    logic [15:0] rd;
    logic        is_read;
    logic        is_init;
  } exp_t;

  exp_t        expq[$];
  int          checks;
  int          fails;
  logic [15:0] resp;
  int          frames_seen;
  int          rsts_seen;
  int          frames_mark;
  int          rsts_mark;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // device model and scoreboard monitor
  logic        prev_clr, prev_strb, prev_rst;
  int          pulses, hi_len, lo_len, clr_len, rst_len;
  logic [23:0] got;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clr = 1'b1; prev_strb = 1'b0; prev_rst = 1'b1;
      pulses = 0; hi_len = 0; lo_len = 0; clr_len = 0; rst_len = 0;
      got = '0; link_dout = 1'b0;
    end else begin
      if (link_strb && !prev_strb) begin
        check(lo_len == ((pulses == 0) ? 2 * LO : LO), "R7/R2 strobe low phase", lo_len,
              (pulses == 0) ? 2 * LO : LO);
        if (pulses < 24) got[pulses] = link_din;
        if (pulses >= 8 && pulses < 24) link_dout = resp[pulses-8];
        pulses++;
        hi_len = 1;
      end else if (!link_strb && prev_strb) begin
        check(hi_len == HI, "R7 strobe high phase", hi_len, HI);
        lo_len = 1;
      end else if (link_strb) begin
        hi_len++;
      end else begin
        lo_len++;
      end
      if (!link_clr_n) clr_len = prev_clr ? 1 : clr_len + 1;
      if (link_clr_n && !prev_clr) begin
        check(clr_len == LO, "R2 clear pulse width", clr_len, LO);
        frames_seen++;
        pulses = 0; got = '0; lo_len = 1;
      end
      if (!link_rst_n) rst_len = prev_rst ? 1 : rst_len + 1;
      if (link_rst_n && !prev_rst) begin
        check(rst_len == LO, "R10 reset pulse width", rst_len, LO);
        rsts_seen++;
      end
      if (done) begin
        check(!busy, "R8 busy low at done", busy, 0);
        if (expq.size() == 0) begin
          check(1'b0, "R9 done without request", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.is_init) begin
            check(rsts_seen - rsts_mark == 1, "R10 one reset pulse", rsts_seen - rsts_mark, 1);
            check(frames_seen == frames_mark, "R10 no frame on init", frames_seen - frames_mark, 0);
          end else begin
            check(frames_seen - frames_mark == 1, "R8 one frame per request", frames_seen - frames_mark, 1);
            check(rsts_seen == rsts_mark, "R8 no reset pulse", rsts_seen - rsts_mark, 0);
            check(pulses == 25, "R6 strobe count", pulses, 25);
            check(got == e.frame, e.is_read ? "R5 read frame bits" : "R3/R4 write frame bits",
                  32'(got), 32'(e.frame));
            if (e.is_read) check(rdata == e.rd, "R5/R9 read data", rdata, e.rd);
          end
        end
        frames_mark = frames_seen;
        rsts_mark   = rsts_seen;
      end
      prev_clr  = link_clr_n;
      prev_strb = link_strb;
      prev_rst  = link_rst_n;
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic do_xfer(input logic wr, input logic [6:0] a, input logic [15:0] d, input logic [15:0] r);
    exp_t e;
    while (busy) @(negedge clk);
    resp = r;
    e.is_init = 1'b0;
    e.is_read = !wr;
    e.rd      = r;
    e.frame   = wr ? {d, a, 1'b1} : {16'h0000, a, 1'b0};
    expq.push_back(e);
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; frames_seen = 0; rsts_seen = 0; frames_mark = 0; rsts_mark = 0;
    resp = '0;
    rst_n = 1'b0; req = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; init_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1 busy after reset", busy, 0);
    check(link_clr_n && link_rst_n, "R1 clear/reset idle high", {link_clr_n, link_rst_n}, 2'b11);
    check(!link_strb && !link_din, "R1 strobe/din idle low", {link_strb, link_din}, 2'b00);

    // writes (R3, R4)
    do_xfer(1'b1, 7'h55, 16'hA5C3, 16'h0);
    do_xfer(1'b1, 7'h7F, 16'hFFFF, 16'h0);
    do_xfer(1'b1, 7'h00, 16'h0000, 16'h0);
    do_xfer(1'b1, 7'h01, 16'h8000, 16'h0);
    // R1 idle between accesses
    @(negedge clk);
    check(link_clr_n && !link_strb && !link_din, "R1 idle levels between accesses",
          {link_clr_n, link_strb, link_din}, 3'b100);

    // reads (R5)
    do_xfer(1'b0, 7'h2A, 16'hFFFF, 16'h8001);
    do_xfer(1'b0, 7'h40, 16'h1234, 16'hFFFF);
    do_xfer(1'b0, 7'h7F, 16'h0000, 16'h0000);
    do_xfer(1'b0, 7'h13, 16'h0000, 16'h1234);

    // R8: requests while busy are ignored
    begin
      exp_t e;
      while (busy) @(negedge clk);
      resp = 16'h0;
      e.is_init = 1'b0; e.is_read = 1'b0; e.rd = '0; e.frame = {16'hBEEF, 7'h33, 1'b1};
      expq.push_back(e);
      req = 1'b1; req_write = 1'b1; req_addr = 7'h33; req_wdata = 16'hBEEF;
      @(negedge clk);
      req = 1'b0;
      check(busy, "R8 busy after accept", busy, 1);
      repeat (5) @(negedge clk);
      req = 1'b1; req_write = 1'b0; req_addr = 7'h11; req_wdata = 16'h1111; init_req = 1'b1;
      @(negedge clk);
      req = 1'b0; init_req = 1'b0;
      repeat (20) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      check(!busy, "R8 ignored request not started", busy, 0);
    end

    // R10: init wins over simultaneous request
    begin
      exp_t e;
      e.is_init = 1'b1; e.is_read = 1'b0; e.rd = '0; e.frame = '0;
      expq.push_back(e);
      init_req = 1'b1; req = 1'b1; req_write = 1'b1; req_addr = 7'h22; req_wdata = 16'h2222;
      @(negedge clk);
      init_req = 1'b0; req = 1'b0;
      check(!link_rst_n, "R10 reset line low", link_rst_n, 0);
      wait_done();
      @(negedge clk);
      check(!busy && link_rst_n, "R10 back to idle", {busy, link_rst_n}, 2'b01);
    end

    // access after init
    do_xfer(1'b1, 7'h6C, 16'h0F0F, 16'h0);
    do_xfer(1'b0, 7'h6C, 16'h0, 16'h5AA5);

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R9 all requests completed", expq.size(), 0);
    finish_run();
  end
endmodule